// File: doc/BRIEF.md
# DC-Balanced Pixel Frame Serializer

This block turns one parallel pixel word per pixel period into a 28-bit serial frame and shifts it out one bit per bit clock. The block runs on the bit clock alone. An internal bit counter marks the pixel period and samples the pixel inputs once every 28 bit clocks. Each frame opens with a high clock bit and closes with a low clock bit, so a receiver can recover the pixel rate from the line. Between those two bits it sends the 24 colour bits, a control/integrity flag and a balance flag.

The colour bits are XORed with an additive LFSR keystream. The result is then sent either as is or bit-inverted. The choice keeps a signed running disparity of the payload close to zero, and the balance flag tells the receiver which was chosen. In 24-bit colour mode the control flag is the even parity of the sent payload XORed with one of the three video control signals. The signal used rotates from frame to frame. In 18-bit colour mode the top six colour bits are forced to zero before scrambling, and the flag carries parity only.

Top module: `pfs_serializer`

## Requirements
- R1: `fs_o` is high for exactly one bit clock in every 28. The first rise comes on the first clock edge after reset is released, and then every 28 edges.
- R2: Frame bit 0, shown while `fs_o` is high, is 1. Frame bit 27, the last bit of the frame, is 0.
- R3: Frame bits 1 to 24 carry payload bits 0 to 23 in that order. The payload is the masked pixel word XOR the LFSR state, or its inverse when R4 applies. The LFSR is seeded to all ones and steps once per frame. A step shifts the state up by one and feeds in bit23^bit22^bit21^bit16 at bit 0.
- R4: Let d be the scrambled word's ones count minus its zeros count. The word is inverted when d is nonzero, the running disparity is nonzero, and both have the same sign. Frame bit 26 is 1 exactly when the word was inverted.
- R5: After each frame, the running disparity changes by the ones-minus-zeros count of the 24 payload bits as sent. It starts at 0 and its magnitude never exceeds 24.
- R6: With `mode24_i`=1, frame bit 25 is the XOR of two values. One is the even-parity bit of the sent payload, which is 1 when the payload has an odd ones count. The other is a control signal chosen by the frame index since reset, modulo 3: 0 picks DE, 1 picks HS, 2 picks VS. The index counts frames in both modes.
- R7: With `mode24_i`=0, pixel bits 23 to 18 are treated as zero before scrambling. `vs_i`, `hs_i` and `de_i` have no effect on the output, and frame bit 25 is the even-parity bit alone.
- R8: While `rst_n` is low, `ser_o` and `fs_o` are 0. Release restarts the LFSR, the disparity and the control rotation.
- R9: Inputs are sampled only on the edge that starts a frame. Changing them anywhere else in the frame does not alter the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 28 times the pixel rate |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_i | input | 24 | Colour bits of the pixel |
| vs_i | input | 1 | Vertical sync |
| hs_i | input | 1 | Horizontal sync |
| de_i | input | 1 | Data enable |
| mode24_i | input | 1 | 1: 24-bit colour mode, 0: 18-bit colour mode |
| ser_o | output | 1 | Serial line bit |
| fs_o | output | 1 | Frame-start strobe, high with the clock-high bit |

## Verification
Inversion and control encoding meet in the same frame. The control flag's parity must be taken over the inverted payload, not the scrambled one. The bench provokes this by sending heavily imbalanced words (all ones, all zeros) back to back while the control signals toggle. That drives the disparity away from zero, so the inversion decision flips while the DE/HS/VS rotation runs. The behavioural model then judges bits 25 and 26 of every frame. A second coincidence is an input change inside a frame that is already being sent. The bench swaps the inputs mid-frame and expects the bits that follow to be unchanged.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    typedef enum logic [1:0] {
        PH_DE = 2'd0,
        PH_HS = 2'd1,
        PH_VS = 2'd2
    } ctl_phase_e;

    function automatic ctl_phase_e next_phase(input ctl_phase_e ph);
        case (ph)
            PH_DE:   return PH_HS;
            PH_HS:   return PH_VS;
            default: return PH_DE;
        endcase
    endfunction

endpackage

// File: rtl/pfs_lfsr_step.sv
module pfs_lfsr_step #(
    parameter int              W    = 24,
    parameter logic [W-1:0]    TAPS = 24'hE1_0000
) (
    input  logic [W-1:0] state_i,
    output logic [W-1:0] state_o
);
    logic fb;

    always_comb begin
        fb      = ^(state_i & TAPS);
        state_o = {state_i[W-2:0], fb};
    end
endmodule

// File: rtl/pfs_balance.sv
module pfs_balance #(
    parameter int PAY_W = 24,
    parameter int RD_W  = 7
) (
    input  logic [PAY_W-1:0]       word_i,
    input  logic signed [RD_W-1:0] rd_i,
    output logic [PAY_W-1:0]       sent_o,
    output logic                   inv_o,
    output logic signed [RD_W-1:0] sent_disp_o
);
    localparam int ONES_W = $clog2(PAY_W + 1);

    logic [ONES_W-1:0]       ones;
    logic signed [RD_W-1:0]  word_disp;

    always_comb begin
        ones = '0;
        for (int i = 0; i < PAY_W; i++) begin
            ones = ones + ONES_W'(word_i[i]);
        end
        word_disp   = RD_W'(2 * int'(ones) - PAY_W);
        inv_o       = (word_disp != 0) && (rd_i != 0) &&
                      (word_disp[RD_W-1] == rd_i[RD_W-1]);
        sent_o      = inv_o ? ~word_i : word_i;
        sent_disp_o = inv_o ? -word_disp : word_disp;
    end
endmodule

// File: rtl/pfs_ctl_encode.sv
module pfs_ctl_encode
    import pfs_pkg::*;
#(
    parameter int PAY_W = 24
) (
    input  logic [PAY_W-1:0] sent_i,
    input  logic             mode24_i,
    input  ctl_phase_e       phase_i,
    input  logic             vs_i,
    input  logic             hs_i,
    input  logic             de_i,
    output logic             flag_o
);
    logic sel;

    always_comb begin
        case (phase_i)
            PH_DE:   sel = de_i;
            PH_HS:   sel = hs_i;
            default: sel = vs_i;
        endcase
        flag_o = (^sent_i) ^ (mode24_i & sel);
    end
endmodule

// File: rtl/pfs_serializer.sv
module pfs_serializer
    import pfs_pkg::*;
#(
    parameter int               PAY_W     = 24,
    parameter int               RED_W     = 18,
    parameter logic [PAY_W-1:0] LFSR_TAPS = 24'hE1_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PAY_W-1:0] pix_i,
    input  logic             vs_i,
    input  logic             hs_i,
    input  logic             de_i,
    input  logic             mode24_i,
    output logic             ser_o,
    output logic             fs_o
);
    localparam int FRAME_W = PAY_W + 4;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam int RD_W    = $clog2(PAY_W) + 2;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]       cnt;
        logic [FRAME_W-1:0]     shreg;
        logic signed [RD_W-1:0] rd;
        logic [PAY_W-1:0]       lfsr;
        ctl_phase_e             phase;
        logic                   ser;
        logic                   fs;
    } st_t;

    st_t st_d, st_q;

    logic [PAY_W-1:0]       masked;
    logic [PAY_W-1:0]       scrambled;
    logic [PAY_W-1:0]       sent;
    logic                   inv;
    logic                   ctl_flag;
    logic signed [RD_W-1:0] sent_disp;
    logic [PAY_W-1:0]       lfsr_nx;
    logic [FRAME_W-1:0]     frame;
    logic signed [RD_W-1:0] rd_now;

    for (genvar g = 0; g < PAY_W; g++) begin : g_mask
        if (g >= RED_W) begin : g_hi
            assign masked[g] = pix_i[g] & mode24_i;
        end else begin : g_lo
            assign masked[g] = pix_i[g];
        end
    end

    assign scrambled = masked ^ st_q.lfsr;

    pfs_lfsr_step #(.W(PAY_W), .TAPS(LFSR_TAPS)) u_lfsr (
        .state_i (st_q.lfsr),
        .state_o (lfsr_nx)
    );

    pfs_balance #(.PAY_W(PAY_W), .RD_W(RD_W)) u_bal (
        .word_i      (scrambled),
        .rd_i        (st_q.rd),
        .sent_o      (sent),
        .inv_o       (inv),
        .sent_disp_o (sent_disp)
    );

    pfs_ctl_encode #(.PAY_W(PAY_W)) u_ctl (
        .sent_i   (sent),
        .mode24_i (mode24_i),
        .phase_i  (st_q.phase),
        .vs_i     (vs_i),
        .hs_i     (hs_i),
        .de_i     (de_i),
        .flag_o   (ctl_flag)
    );

    assign frame  = {1'b0, inv, ctl_flag, sent, 1'b1};
    assign rd_now = st_q.rd;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == '0) begin
            st_d.ser   = frame[0];
            st_d.shreg = frame >> 1;
            st_d.fs    = 1'b1;
            st_d.lfsr  = lfsr_nx;
            st_d.rd    = st_q.rd + sent_disp;
            st_d.phase = next_phase(st_q.phase);
        end else begin
            st_d.ser   = st_q.shreg[0];
            st_d.shreg = st_q.shreg >> 1;
            st_d.fs    = 1'b0;
        end
        st_d.cnt = (st_q.cnt == CNT_LAST) ? '0 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.shreg <= '0;
            st_q.rd    <= '0;
            st_q.lfsr  <= '1;
            st_q.phase <= PH_DE;
            st_q.ser   <= 1'b0;
            st_q.fs    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_o = st_q.ser;
    assign fs_o  = st_q.fs;

endmodule

// File: rtl/pfs_serializer_chk.sv
module pfs_serializer_chk #(
    parameter int PAY_W = 24
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             ser_o,
    input logic                             fs_o,
    input logic signed [$clog2(PAY_W)+1:0]  rd
);
    localparam int FRAME_W = PAY_W + 4;
    localparam int GAP_W   = $clog2(FRAME_W) + 1;
    localparam logic [GAP_W-1:0] GAP_MAX = '1;

    logic             started_q;
    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            gap_q     <= '0;
        end else if (fs_o) begin
            started_q <= 1'b1;
            gap_q     <= '0;
        end else if (gap_q != GAP_MAX) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assert_fs_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fs_o |=> !fs_o);

    assert_frame_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> (fs_o == (gap_q == GAP_W'(FRAME_W - 1))));

    assert_clk_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fs_o |-> ser_o);

    assert_clk_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && gap_q == GAP_W'(FRAME_W - 2)) |-> !ser_o);

    assert_rd_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd) <= PAY_W) && (int'(rd) >= -PAY_W));

endmodule

bind pfs_serializer pfs_serializer_chk #(.PAY_W(PAY_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ser_o (ser_o),
    .fs_o  (fs_o),
    .rd    (rd_now)
);

// File: tb/sim_pfs_serializer.sv
module sim_pfs_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pix = '0;
    logic        vs = 1'b0, hs = 1'b0, de = 1'b0, m24 = 1'b1;
    logic        ser, fs;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [23:0] m_lfsr;
    int          m_rd;
    int          m_phase;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfs_serializer u0 (
        .clk(clk), .rst_n(rst_n), .pix_i(pix), .vs_i(vs), .hs_i(hs),
        .de_i(de), .mode24_i(m24), .ser_o(ser), .fs_o(fs)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_lfsr  = '1;
        m_rd    = 0;
        m_phase = 0;
    endtask

    function automatic logic [27:0] build_frame();
        logic [23:0] w;
        logic [23:0] s;
        int          ones;
        int          d;
        logic        inv;
        logic        ctl;
        logic        sel;
        w = pix;
        if (!m24) w[23:18] = '0;
        s = w ^ m_lfsr;
        ones = 0;
        for (int i = 0; i < 24; i++) ones += int'(s[i]);
        d = 2 * ones - 24;
        inv = (d != 0) && (m_rd != 0) && ((d > 0) == (m_rd > 0));
        if (inv) begin
            s = ~s;
            d = -d;
        end
        ones = 0;
        for (int i = 0; i < 24; i++) ones += int'(s[i]);
        sel = (m_phase == 0) ? de : (m_phase == 1) ? hs : vs;
        ctl = logic'(ones % 2) ^ (m24 & sel);
        m_rd = m_rd + d;
        m_phase = (m_phase + 1) % 3;
        m_lfsr = {m_lfsr[22:0], m_lfsr[23] ^ m_lfsr[22] ^ m_lfsr[21] ^ m_lfsr[16]};
        return {1'b0, inv, ctl, s, 1'b1};
    endfunction

    // Called at a negedge, just before the frame-start edge.
    task automatic run_frame(input logic [23:0] p, input logic v, input logic h,
                             input logic e, input logic mode, input bit glitch);
        logic [27:0] exp_f;
        string       extra;
        pix = p; vs = v; hs = h; de = e; m24 = mode;
        exp_f = build_frame();
        extra = mode ? "" : " R7";
        for (int i = 0; i < FW; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == 0 || i == 27)      check($sformatf("R2%s", extra), ser, exp_f[i]);
            else if (i <= 24)           check($sformatf("R3%s%s", extra, glitch ? " R9" : ""), ser, exp_f[i]);
            else if (i == 25)           check($sformatf("R6%s", extra), ser, exp_f[i]);
            else                        check("R4 R5", ser, exp_f[i]);
            check("R1", fs, logic'(i == 0));
            if (glitch && i == 4) begin
                pix = ~p; vs = ~v; hs = ~h; de = ~e; m24 = ~mode;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check("R8", ser, 1'b0);
        check("R8", fs, 1'b0);
        rst_n = 1'b1;
        // 24-bit mode: imbalanced words with toggling controls
        run_frame(24'hFFFFFF, 1'b0, 1'b1, 1'b1, 1'b1, 0);
        run_frame(24'hFFFFFF, 1'b1, 1'b0, 1'b1, 1'b1, 0);
        run_frame(24'h000000, 1'b1, 1'b1, 1'b0, 1'b1, 0);
        run_frame(24'hFFFFFF, 1'b0, 1'b0, 1'b1, 1'b1, 0);
        run_frame(24'hAAAAAA, 1'b1, 1'b0, 1'b0, 1'b1, 0);
        run_frame(24'h123456, 1'b0, 1'b1, 1'b0, 1'b1, 0);
        for (int k = 0; k < 12; k++) begin
            run_frame(24'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b1, 0);
        end
        // 18-bit mode: upper bits and controls must not matter
        run_frame(24'hFC0000, 1'b1, 1'b1, 1'b1, 1'b0, 0);
        run_frame(24'hFFFFFF, 1'b0, 1'b1, 1'b0, 1'b0, 0);
        for (int k = 0; k < 6; k++) begin
            run_frame(24'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b0, 0);
        end
        // inputs changed mid-frame
        run_frame(24'h0F0F0F, 1'b1, 1'b0, 1'b1, 1'b1, 1);
        run_frame(24'h3C00FF, 1'b0, 1'b1, 1'b1, 1'b0, 1);
        run_frame(24'hFFFFFF, 1'b1, 1'b1, 1'b1, 1'b1, 1);
        // reset in the middle of a frame
        pix = 24'h55AA55; m24 = 1'b1;
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8", ser, 1'b0);
        check("R8", fs, 1'b0);
        model_reset();
        rst_n = 1'b1;
        run_frame(24'h000000, 1'b0, 1'b0, 1'b1, 1'b1, 0);
        run_frame(24'hFFFFFF, 1'b0, 1'b1, 1'b0, 1'b1, 0);
        for (int k = 0; k < 8; k++) begin
            run_frame(24'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 0);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule